// File: doc/BRIEF.md
# Byte-Register Bridge to a Handshaked 16-bit Configuration Bus

This block lets a processor that only sees byte-wide registers drive a 16-bit configuration bus that has a 7-bit address, a one-cycle enable, a write-enable and a ready return. Software stages the 16-bit value in two byte registers. A single write to the command register then launches one bus read or one bus write. A read lands both bytes of the returned word in the same two byte registers. A bus that never answers is cut off after a fixed number of cycles.

A control register handles device attachment. Software first enters a select mode, then picks the device, then leaves select mode, and only at that point does the device become attached. Bus commands are accepted only while a device is attached. Outside select mode, two bits of the same control register drive a device reset level and a conversion-start level.

The register port decodes a 2-bit index: 0 is control, 1 is command, 2 is the low data byte and 3 is the high data byte. Reads of the register port are combinational.

Top module: `cfgbus_bridge`

## Requirements
- R1: After hard reset all four registers read 0x00 and `bus_en`, `bus_we`, `busy`, `dev_attached`, `dev_rst` and `conv_start` are low.
- R2: A control write with bit 7 = 1 enters select mode (control readback bit 7 = 1) and leaves `dev_rst` and `conv_start` unchanged, whatever bits 6 and 0 hold.
- R3: A control write with bits 7 and 6 both set records a device choice. The next control write with bit 7 = 0 leaves select mode and raises `dev_attached` (control readback bit 1) only if a choice was recorded. Entering select mode detaches.
- R4: A control write with bit 7 = 0 sets `dev_rst` to bit 6 and `conv_start` to bit 0. These are read back at bits 6 and 0.
- R5: A command write while attached and idle raises `bus_en` for exactly one cycle, starting the cycle after the write. `bus_addr` carries command bits 6:0, and `bus_we` is high in that cycle only if command bit 7 = 1.
- R6: Command readback returns the launched address in bits 6:0, and bit 7 always reads 0.
- R7: During a bus write, `bus_wdata` carries the high data register in bits 15:8 and the low data register in bits 7:0.
- R8: On a bus read, the cycle in which `bus_rdy` is seen loads `bus_rdata[7:0]` into the low data register and `bus_rdata[15:8]` into the high data register.
- R9: `busy` rises together with `bus_en` and falls after the first busy cycle with `bus_rdy` high. A ready answer in busy cycle k (k counted from 0) gives k+1 busy cycles. Command writes and `bus_rdy` while busy do not start a new transaction, and `bus_rdy` while idle is ignored.
- R10: If `bus_rdy` is not seen within 64 busy cycles, the transaction ends after exactly 64 busy cycles. A read that times out leaves 0xFF in both data registers, and a write that times out leaves them unchanged.
- R11: A command write while no device is attached is ignored: no `bus_en`, and the command readback is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low |
| reg_idx | input | 2 | Register index: 0 control, 1 command, 2 data low, 3 data high |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx` (combinational) |
| bus_addr | output | 7 | Configuration bus register address |
| bus_en | output | 1 | One-cycle transaction enable |
| bus_we | output | 1 | Write qualifier, high only together with `bus_en` |
| bus_wdata | output | 16 | Write data from the two data registers |
| bus_rdata | input | 16 | Read data returned with `bus_rdy` |
| bus_rdy | input | 1 | Transaction completion from the bus |
| dev_rst | output | 1 | Device reset level |
| conv_start | output | 1 | Conversion start level |
| dev_attached | output | 1 | A device is attached to the bridge |
| busy | output | 1 | Transaction in flight |

## Verification
The checker watches several properties on every cycle:
- the enable pulse lasts one cycle and the write qualifier never appears without it;
- busy rises with the enable and drops right after a ready answer or the timeout;
- no busy period exceeds 64 cycles, and no enable appears while detached;
- select-mode writes leave the reset and start levels alone, and the command readback bit 7 stays 0.

Other behaviour can only be shown by the bench's scenarios, which use a latency-programmable responder with its own memory:
- that the right word arrives at the right address;
- that read data lands in the right byte registers;
- the exact busy length on either side of the 64-cycle limit, including the 0xFFFF fill after a timeout;
- that commands and late ready answers arriving at the wrong time change nothing visible.

// File: rtl/cfgbus_bridge_pkg.sv
package cfgbus_bridge_pkg;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CMD  = 2'd1,
    IDX_DLO  = 2'd2,
    IDX_DHI  = 2'd3
  } reg_idx_e;

  // control readback layout: select mode, reset level, attached, start level
  function automatic logic [7:0] ctrl_view(logic sel, logic rst, logic att, logic conv);
    return {sel, rst, 4'b0000, att, conv};
  endfunction

  // command readback: operation bit always hidden
  function automatic logic [7:0] cmd_view(logic [6:0] addr);
    return {1'b0, addr};
  endfunction

  // true when the current busy cycle is the last one the window allows
  function automatic logic window_spent(int unsigned elapsed, int unsigned limit);
    return (elapsed + 1) >= limit;
  endfunction

endpackage

// File: rtl/cfgbus_ctrl_reg.sv
module cfgbus_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_sel,
  input  logic w_b6,
  input  logic w_b0,
  output logic sel_mode,
  output logic attached,
  output logic dev_rst,
  output logic conv_start
);

  logic chosen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_mode   <= 1'b0;
      attached   <= 1'b0;
      dev_rst    <= 1'b0;
      conv_start <= 1'b0;
      chosen     <= 1'b0;
    end else if (wr) begin
      if (w_sel) begin
        // select mode: only the device choice may change
        sel_mode <= 1'b1;
        attached <= 1'b0;
        if (w_b6) chosen <= 1'b1;
      end else begin
        dev_rst    <= w_b6;
        conv_start <= w_b0;
        if (sel_mode) begin
          attached <= chosen;
          chosen   <= 1'b0;
          sel_mode <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_bridge_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              attached,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_en,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              busy,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_data,
  output logic              evt_launch,
  output logic              evt_ack,
  output logic              evt_timeout
);

  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic [CNT_W-1:0] wait_cnt;
  logic             op_we;

  assign evt_launch  = cmd_wr && !busy && attached;
  assign evt_ack     = busy && bus_rdy;
  assign evt_timeout = busy && !bus_rdy && window_spent(int'(wait_cnt), TIMEOUT);
  assign cap_en      = (evt_ack || evt_timeout) && !op_we;
  assign cap_data    = evt_ack ? bus_rdata : {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bus_en   <= 1'b0;
      bus_we   <= 1'b0;
      bus_addr <= '0;
      op_we    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      bus_en <= evt_launch;
      bus_we <= evt_launch && cmd_op;
      if (evt_launch) begin
        busy     <= 1'b1;
        bus_addr <= cmd_addr;
        op_we    <= cmd_op;
        wait_cnt <= '0;
      end else if (evt_ack || evt_timeout) begin
        busy <= 1'b0;
      end else if (busy) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgbus_bridge.sv
module cfgbus_bridge
  import cfgbus_bridge_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_idx,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [REG_W-2:0]   bus_addr,
  output logic               bus_en,
  output logic               bus_we,
  output logic [2*REG_W-1:0] bus_wdata,
  input  logic [2*REG_W-1:0] bus_rdata,
  input  logic               bus_rdy,
  output logic               dev_rst,
  output logic               conv_start,
  output logic               dev_attached,
  output logic               busy
);

  localparam int ADDR_W = REG_W - 1;
  localparam int DATA_W = 2 * REG_W;

  reg_idx_e          idx;
  logic              ctrl_wr, cmd_wr, lo_wr, hi_wr;
  logic              sel_mode;
  logic              cap_en;
  logic [DATA_W-1:0] cap_data;
  logic [REG_W-1:0]  data_lo, data_hi;
  logic              evt_launch, evt_ack, evt_timeout;

  assign idx     = reg_idx_e'(reg_idx);
  assign ctrl_wr = reg_wr && (idx == IDX_CTRL);
  assign cmd_wr  = reg_wr && (idx == IDX_CMD);
  assign lo_wr   = reg_wr && (idx == IDX_DLO);
  assign hi_wr   = reg_wr && (idx == IDX_DHI);

  cfgbus_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctrl_wr),
    .w_sel     (reg_wdata[REG_W-1]),
    .w_b6      (reg_wdata[REG_W-2]),
    .w_b0      (reg_wdata[0]),
    .sel_mode  (sel_mode),
    .attached  (dev_attached),
    .dev_rst   (dev_rst),
    .conv_start(conv_start)
  );

  cfgbus_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIMEOUT(TIMEOUT)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_op     (reg_wdata[REG_W-1]),
    .cmd_addr   (reg_wdata[ADDR_W-1:0]),
    .attached   (dev_attached),
    .bus_rdy    (bus_rdy),
    .bus_rdata  (bus_rdata),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .busy       (busy),
    .cap_en     (cap_en),
    .cap_data   (cap_data),
    .evt_launch (evt_launch),
    .evt_ack    (evt_ack),
    .evt_timeout(evt_timeout)
  );

  // data staging: a bus read result takes precedence over a software byte write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_lo <= '0;
      data_hi <= '0;
    end else if (cap_en) begin
      data_lo <= cap_data[REG_W-1:0];
      data_hi <= cap_data[DATA_W-1:REG_W];
    end else begin
      if (lo_wr) data_lo <= reg_wdata;
      if (hi_wr) data_hi <= reg_wdata;
    end
  end

  assign bus_wdata = {data_hi, data_lo};

  always_comb begin
    unique case (idx)
      IDX_CTRL: reg_rdata = ctrl_view(sel_mode, dev_rst, dev_attached, conv_start);
      IDX_CMD:  reg_rdata = cmd_view(bus_addr);
      IDX_DLO:  reg_rdata = data_lo;
      IDX_DHI:  reg_rdata = data_hi;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgbus_bridge_chk.sv
module cfgbus_bridge_chk #(
  parameter int TIMEOUT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_idx,
  input logic       reg_wr,
  input logic       wd_b7,
  input logic       wd_b6,
  input logic       wd_b0,
  input logic       rd_b7,
  input logic       bus_en,
  input logic       bus_we,
  input logic       busy,
  input logic       dev_attached,
  input logic       dev_rst,
  input logic       conv_start,
  input logic       evt_launch,
  input logic       evt_ack,
  input logic       evt_timeout
);

  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= busy ? run + 1 : 0;
  end

  assert_sel_noeffect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd0 && wd_b7) |=> ($stable(dev_rst) && $stable(conv_start)));

  assert_levels_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 2'd0 && !wd_b7) |=> (dev_rst == $past(wd_b6) && conv_start == $past(wd_b0)));

  assert_en_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> !bus_en);

  assert_we_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_en);

  assert_launch_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_launch |=> (bus_en && busy));

  assert_cmd_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 2'd1) |-> !rd_b7);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_en);

  assert_ack_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack |=> !busy);

  assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < TIMEOUT));

  assert_timeout_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |-> (run == TIMEOUT - 1));

  assert_en_attached_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_launch |-> dev_attached);

endmodule

bind cfgbus_bridge cfgbus_bridge_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_idx     (reg_idx),
  .reg_wr      (reg_wr),
  .wd_b7       (reg_wdata[REG_W-1]),
  .wd_b6       (reg_wdata[REG_W-2]),
  .wd_b0       (reg_wdata[0]),
  .rd_b7       (reg_rdata[REG_W-1]),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .busy        (busy),
  .dev_attached(dev_attached),
  .dev_rst     (dev_rst),
  .conv_start  (conv_start),
  .evt_launch  (evt_launch),
  .evt_ack     (evt_ack),
  .evt_timeout (evt_timeout)
);

// File: tb/cfgbus_bridge_bench.sv
module cfgbus_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {we, addr[6:0], data[15:0], latency[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 7'h10, 16'h1234, 8'd0},
    {1'b1, 7'h7F, 16'hBEEF, 8'd5},
    {1'b0, 7'h10, 16'h0000, 8'd3},
    {1'b0, 7'h7F, 16'h0000, 8'd0},
    {1'b0, 7'h00, 16'h0000, 8'd10},
    {1'b1, 7'h00, 16'h0F0F, 8'd2},
    {1'b0, 7'h00, 16'h0000, 8'd62}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [6:0]  bus_addr;
  logic        bus_en, bus_we;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rdy;
  logic        dev_rst, conv_start, dev_attached, busy;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbus_bridge u_cfgbus_bridge (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .dev_rst(dev_rst),
    .conv_start(conv_start), .dev_attached(dev_attached), .busy(busy)
  );

  function automatic logic [15:0] seed(int a);
    return 16'(a * 771) ^ 16'hA5C3;
  endfunction

  // responder with programmable latency
  logic [15:0] rmem [128];
  logic [15:0] exp_mem [128];
  logic        pend = 1'b0;
  int          rcnt = 0;
  int          lat_cfg = 0;
  logic [6:0]  rd_addr = 7'd0;
  int          en_count = 0;
  logic [6:0]  mon_addr = 7'd0;
  logic        mon_we = 1'b0;

  initial begin
    for (int a = 0; a < 128; a++) begin
      rmem[a] = seed(a);
      exp_mem[a] = seed(a);
    end
  end

  assign bus_rdy   = pend && (rcnt == 0);
  assign bus_rdata = bus_rdy ? rmem[rd_addr] : 16'h0BAD;

  always @(posedge clk) begin
    if (bus_en) begin
      pend     <= 1'b1;
      rcnt     <= lat_cfg;
      rd_addr  <= bus_addr;
      mon_addr <= bus_addr;
      mon_we   <= bus_we;
      en_count <= en_count + 1;
      if (bus_we) rmem[bus_addr] <= bus_wdata;
    end else if (pend) begin
      if (rcnt == 0) pend <= 1'b0;
      else           rcnt <= rcnt - 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] i, logic [7:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] i, output logic [7:0] d);
    reg_idx = i;
    #1;
    d = reg_rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd_reg(2'd2, lo);
    rd_reg(2'd3, hi);
    w = {hi, lo};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] w;
    int          n, e0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd_reg(2'(i), r);
      chk("R1 reg reset", r, 0);
    end
    chk("R1 outputs reset", {bus_en, bus_we, busy, dev_attached, dev_rst, conv_start}, 0);

    // R11 command while detached
    e0 = en_count;
    wr_reg(2'd1, 8'h05);
    repeat (3) @(negedge clk);
    chk("R11 no enable detached", en_count - e0, 0);
    rd_reg(2'd1, r);
    chk("R11 cmd unchanged", r, 8'h00);

    // R2 select mode, R3 attach, R4 levels
    wr_reg(2'd0, 8'h80);
    rd_reg(2'd0, r);
    chk("R2 select mode readback", r, 8'h80);
    wr_reg(2'd0, 8'hC1);
    rd_reg(2'd0, r);
    chk("R2 bit6/bit0 no effect in select", {r, dev_rst, conv_start}, {8'h80, 2'b00});
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, r);
    chk("R3 attached after leaving select", {r, dev_attached}, {8'h02, 1'b1});
    wr_reg(2'd0, 8'h41);
    rd_reg(2'd0, r);
    chk("R4 levels set", {r, dev_rst, conv_start}, {8'h43, 2'b11});
    wr_reg(2'd0, 8'hC0);
    chk("R2 levels held on select entry", {dev_rst, conv_start, dev_attached}, 3'b110);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, r);
    chk("R4 levels cleared and R3 reattached", {r, dev_rst, conv_start}, {8'h02, 2'b00});

    // vector table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic        we;
      logic [6:0]  a;
      logic [15:0] d;
      int          lat;
      we  = VEC[v][31];
      a   = VEC[v][30:24];
      d   = VEC[v][23:8];
      lat = int'(VEC[v][7:0]);
      if (we) begin
        wr_reg(2'd2, d[7:0]);
        wr_reg(2'd3, d[15:8]);
      end
      lat_cfg = lat;
      e0 = en_count;
      wr_reg(2'd1, {we, a});
      count_busy(n);
      chk("R5 single enable", en_count - e0, 1);
      chk("R5 address and op", {mon_we, mon_addr}, {we, a});
      chk("R9 busy length", n, lat + 2);
      rd_reg(2'd1, r);
      chk("R6 cmd readback", r, {1'b0, a});
      if (we) begin
        chk("R7 word written", rmem[a], d);
        exp_mem[a] = d;
      end else begin
        rd_word(w);
        chk("R8 word captured", w, exp_mem[a]);
      end
    end

    // R9 command while busy ignored
    lat_cfg = 20;
    e0 = en_count;
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd1, 8'h85);
    count_busy(n);
    repeat (3) @(negedge clk);
    chk("R9 one enable despite second cmd", en_count - e0, 1);
    rd_reg(2'd1, r);
    chk("R9 cmd not replaced while busy", r, 8'h11);
    rd_word(w);
    chk("R9 data from first read", w, exp_mem[7'h11]);

    // R10 read timeout, then late ready ignored
    lat_cfg = 63;
    wr_reg(2'd1, 8'h22);
    count_busy(n);
    chk("R10 timeout busy length", n, 64);
    rd_word(w);
    chk("R10 timeout fill", w, 16'hFFFF);
    repeat (4) @(negedge clk);
    rd_word(w);
    chk("R9 late ready ignored", w, 16'hFFFF);

    // R10 write timeout leaves data alone
    wr_reg(2'd2, 8'h3C);
    wr_reg(2'd3, 8'hC3);
    lat_cfg = 63;
    wr_reg(2'd1, 8'hA3);
    count_busy(n);
    chk("R10 write timeout length", n, 64);
    rd_word(w);
    chk("R10 write timeout keeps data", w, 16'hC33C);
    repeat (4) @(negedge clk);

    // R3 detach by select without choice, then R11
    wr_reg(2'd0, 8'h80);
    chk("R3 select detaches", dev_attached, 1'b0);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, r);
    chk("R3 no choice stays detached", r, 8'h00);
    e0 = en_count;
    wr_reg(2'd1, 8'h05);
    repeat (3) @(negedge clk);
    chk("R11 ignored after detach", en_count - e0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule